// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level page table through a simple read port that handles one request at a time. A requester presents a virtual address and an access type, which is either read or write. The walker reads the top-level entry and then, if that entry is present, the leaf entry. It answers with a one-cycle completion pulse. The pulse carries either a physical address or a fault code. The fault code tells apart three cases: a missing second-level table, a missing data page, and an access that the leaf does not permit.

The top-level table sits at the 4 KB-aligned address given on the table base input. Each table entry is a 32-bit word with these fields:

| Bits | Meaning |
|------|---------|
| 31:12 | Frame number, or the base of the next table |
| 2 | Write allowed |
| 1 | Read allowed |
| 0 | Present |
| 11:3 | Ignored |

The walker keeps no record of earlier walks. It accepts a new request only while idle.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low.
- R2: When a request is accepted (`req_valid` high while idle), `busy` goes high on the next cycle. On that same cycle `mem_req` pulses for one cycle with `mem_addr` = {`pt_base`[31:12], 12'h0} + 4·`req_vaddr`[31:24].
- R3: If the top-level entry has bit 0 clear, the walk ends with `fault` = 1 (table missing) and `paddr` = 0. No second read is issued.
- R4: If the top-level entry has bit 0 set, the second read has `mem_addr` = {entry[31:12], 12'h0} + 4·vaddr[23:12].
- R5: If the leaf entry has bit 0 clear, the walk ends with `fault` = 2 (page missing) and `paddr` = 0.
- R6: A read access (`req_write` = 0) to a present leaf whose bit 1 is clear ends with `fault` = 3 (permission denied) and `paddr` = 0.
- R7: A write access (`req_write` = 1) to a present leaf whose bit 2 is clear ends with `fault` = 3 and `paddr` = 0.
- R8: A permitted access ends with `fault` = 0 and `paddr` = {leaf[31:12], vaddr[11:0]}.
- R9: At most one memory read is outstanding at a time. `busy` stays high from acceptance until the cycle `done` pulses, and is low in that cycle. A `req_valid` raised while busy is ignored and does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pt_base | input | 32 | Top-level table base; bits 11:0 are ignored |
| req_valid | input | 1 | Translate request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access type: 1 for write, 0 for read |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 0 ok, 1 table missing, 2 page missing, 3 permission denied |
| paddr | output | 32 | Physical address; 0 on a fault |
| mem_req | output | 1 | One-cycle read request pulse |
| mem_addr | output | 32 | Read address, held until the response |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read |

## Verification
The bench sweeps many top-level indices against leaf indices that span the whole 12-bit range, including 0 and 4095. Each combination is tried as a read and as a write. Its memory model computes every entry from its address. Top-level presence, leaf presence and the read/write flags follow different moduli, so each fault code and the success path appear for both access types. The same sweep separates a top-level miss from a leaf miss, and a missing page from a permission failure. Varying memory latency and a stray request during each walk show that read addresses, read counts and results do not depend on response timing or on input activity while busy.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int OFF_W = 12,
  parameter int TOP_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] pt_base,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  output logic        busy,
  output logic        done,
  output logic [1:0]  fault,
  output logic [31:0] paddr,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  localparam int MID_W = 32 - OFF_W - TOP_W;
  localparam logic [1:0] F_OK = 2'd0, F_TBL = 2'd1, F_PG = 2'd2, F_PERM = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_TOP, S_LEAF} st_t;
  st_t st;

  logic [31:0] va_q;
  logic        wr_q;

  wire perm_ok = wr_q ? mem_rsp_data[2] : mem_rsp_data[1];
  wire [31:0] top_addr  = {pt_base[31:OFF_W], {OFF_W{1'b0}}} + 32'({req_vaddr[31 -: TOP_W], 2'b00});
  wire [31:0] leaf_addr = {mem_rsp_data[31:OFF_W], {OFF_W{1'b0}}} + 32'({va_q[OFF_W +: MID_W], 2'b00});

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      va_q     <= '0;
      wr_q     <= 1'b0;
      done     <= 1'b0;
      fault    <= F_OK;
      paddr    <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else begin
      done    <= 1'b0;
      mem_req <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q     <= req_vaddr;
          wr_q     <= req_write;
          mem_addr <= top_addr;
          mem_req  <= 1'b1;
          st       <= S_TOP;
        end
        S_TOP: if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            done  <= 1'b1;
            fault <= F_TBL;
            paddr <= '0;
            st    <= S_IDLE;
          end else begin
            mem_addr <= leaf_addr;
            mem_req  <= 1'b1;
            st       <= S_LEAF;
          end
        end
        S_LEAF: if (mem_rsp_valid) begin
          done <= 1'b1;
          st   <= S_IDLE;
          if (!mem_rsp_data[0]) begin
            fault <= F_PG;
            paddr <= '0;
          end else if (!perm_ok) begin
            fault <= F_PERM;
            paddr <= '0;
          end else begin
            fault <= F_OK;
            paddr <= {mem_rsp_data[31:OFF_W], va_q[OFF_W-1:0]};
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pt_base,
  input logic        req_valid,
  input logic [31:0] req_vaddr,
  input logic        req_write,
  input logic        busy,
  input logic        done,
  input logic [1:0]  fault,
  input logic [31:0] paddr,
  input logic        mem_req,
  input logic        mem_rsp_valid,
  input logic [31:0] mem_rsp_data
);
  logic       wr_t;
  logic [1:0] nrsp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_t <= 1'b0;
      nrsp <= '0;
    end else if (!busy && req_valid) begin
      wr_t <= req_write;
      nrsp <= '0;
    end else if (mem_rsp_valid && nrsp != 2'd3) begin
      nrsp <= nrsp + 2'd1;
    end
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |-> (!done && !mem_req));
  a_r2_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> (busy && mem_req));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r3_top_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rsp_valid && nrsp == 2'd0 && !mem_rsp_data[0]) |=> (done && fault == 2'd1 && !mem_req));
  a_r5_leaf_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rsp_valid && nrsp == 2'd1 && !mem_rsp_data[0]) |=> (done && fault == 2'd2));
  a_r7_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rsp_valid && nrsp == 2'd1 && mem_rsp_data[0] &&
     !(wr_t ? mem_rsp_data[2] : mem_rsp_data[1])) |=> (done && fault == 2'd3 && paddr == 32'd0));
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] pt_base = 32'h0010_0000;
  logic req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_write = 1'b0;
  logic busy, done, mem_req;
  logic [1:0] fault;
  logic [31:0] paddr, mem_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int errs = 0, checks = 0;
  int reads = 0, outstanding = 0, lat_sel = 0;
  logic [31:0] cur_va = '0;
  logic timed_out = 1'b0;

  always #10 clk = ~clk;

  pt_walker u_pt_walker (.*);

  function automatic logic [31:0] entry(input logic [31:0] a);
    logic [19:0] t;
    logic [7:0] i;
    logic [11:0] j;
    logic [1:0] pm;
    logic [19:0] fr;
    if (a[31:12] == 20'h00100) begin
      i = a[9:2];
      return {20'(20'h200 + {i, 2'b00}), 9'h15A, 2'b11, (i % 4) != 3};
    end
    t = a[31:12] - 20'h200;
    i = t[9:2];
    j = a[13:2];
    pm = 2'((i + j) % 4);
    fr = {i, j} ^ 20'h5A5A5;
    return {fr, 9'h0A3, pm[1], pm[0], (j % 5) != 4};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: latency 1..3 cycles, address checks at the request
  logic [31:0] pend_addr;
  int pend_cnt = -1;
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (reads == 0)
        chk(mem_addr == (pt_base + {22'd0, cur_va[31:24], 2'b00}), "R2 top read addr", mem_addr,
            pt_base + {22'd0, cur_va[31:24], 2'b00});
      else
        chk(mem_addr == ((32'h200 + {22'd0, cur_va[31:24], 2'b00}) << 12) + {18'd0, cur_va[23:12], 2'b00},
            "R4 leaf read addr", mem_addr,
            ((32'h200 + {22'd0, cur_va[31:24], 2'b00}) << 12) + {18'd0, cur_va[23:12], 2'b00});
      chk(outstanding == 0, "R9 single outstanding", outstanding, 0);
      reads++;
      outstanding++;
      pend_addr = mem_addr;
      pend_cnt = lat_sel % 3;
      lat_sel++;
    end
  end

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend_cnt == 0) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= entry(pend_addr);
      outstanding   <= 0;
      pend_cnt      <= -1;
    end else if (pend_cnt > 0) begin
      pend_cnt <= pend_cnt - 1;
    end
  end

  task automatic translate(input logic [31:0] va, input bit wr);
    logic [7:0] i;
    logic [11:0] j;
    logic [1:0] pm;
    logic [1:0] ef;
    logic [31:0] ep;
    int n;
    i = va[31:24];
    j = va[23:12];
    pm = 2'((i + j) % 4);
    ep = 32'd0;
    if ((i % 4) == 3) ef = 2'd1;
    else if ((j % 5) == 4) ef = 2'd2;
    else if (!(wr ? pm[1] : pm[0])) ef = 2'd3;
    else begin
      ef = 2'd0;
      ep = {({i, j} ^ 20'h5A5A5), va[11:0]};
    end
    @(negedge clk);
    cur_va = va;
    reads = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    req_write = wr;
    @(negedge clk);
    chk(busy, "R2 busy after accept", busy, 1);
    req_valid = 1'b1;
    req_vaddr = ~va;
    req_write = ~wr;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      chk(busy, "R9 busy during walk", busy, 1);
      @(negedge clk);
      n++;
    end
    chk(done, "R9 walk completes", done, 1);
    chk(!busy, "R9 idle at done", busy, 0);
    if (ef == 2'd1) chk(fault == ef, "R3 table missing", fault, ef);
    else if (ef == 2'd2) chk(fault == ef, "R5 page missing", fault, ef);
    else if (ef == 2'd3 && wr) chk(fault == ef, "R7 write denied", fault, ef);
    else if (ef == 2'd3) chk(fault == ef, "R6 read denied", fault, ef);
    else chk(fault == ef, "R8 ok code", fault, ef);
    chk(paddr == ep, "R8 paddr", paddr, ep);
    chk(reads == ((ef == 2'd1) ? 1 : 2), "R3 read count", reads, (ef == 2'd1) ? 1 : 2);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
  endtask

  initial begin
    #2000000;
    timed_out = 1'b1;
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [11:0] js [12];
    js = '{12'd0, 12'd1, 12'd2, 12'd3, 12'd4, 12'd9, 12'd100, 12'd1023,
           12'd2048, 12'd3001, 12'd4094, 12'd4095};
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 reset state", {busy, done, mem_req}, 0);
    rst_n = 1'b1;
    for (int ii = 0; ii < 18; ii++) begin
      logic [7:0] iv;
      iv = (ii < 16) ? 8'(ii) : ((ii == 16) ? 8'd128 : 8'd255);
      for (int jj = 0; jj < 12; jj++) begin
        for (int w = 0; w < 2; w++) begin
          translate({iv, js[jj], 12'(ii * 37 + jj * 91 + w)}, w[0]);
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule